// File: doc/BRIEF.md
# Clock Calibrate-and-Hold Controller

This block sequences a low-power clock generator through a single calibration. While an analog frequency-locked loop settles against an external reference clock, the controller keeps every loop block powered and leaves the oscillator on the amplifier path. After a programmable settling time it digitizes the loop's control voltage with a 10-bit successive-approximation search. It drives trial codes to a search DAC and reads back one comparator bit per step.

The final code is latched into a hold register that drives a hold DAC. The controller then raises its done flag, moves the oscillator source to the hold DAC and removes the enables of the amplifier, both frequency-to-voltage converters, the counter and the converter logic. Once this has happened the reference may be switched off. A calibrate request, honoured only in retention, or a reset starts the sequence again.

Top module: `clk_cal_hold_ctrl`

## Requirements
- R1: Phases advance only in the order calibrate, convert, latch, retain. Retain is left only through a calibrate request or a reset.
- R2: Reset sets done, osc_sel_hold, hold_code and trial_code to 0, and sets all five loop enables to 1.
- R3: Calibration lasts exactly SETTLE_CYCLES clock cycles. trial_code stays 0 throughout calibration.
- R4: In the first conversion cycle trial_code is 10'h200, with only bit 9 set.
- R5: Bits are resolved from bit 9 down to bit 0, one per cycle. cmp_bit is sampled at the edge that ends the cycle in which the trial is presented, and that edge also sets the next lower bit as the new trial bit.
- R6: cmp_bit = 1 keeps the tested bit at 1. cmp_bit = 0 clears the tested bit.
- R7: The conversion takes 10 decision cycles and then 1 latch cycle. done rises SETTLE_CYCLES + 11 cycles after calibration starts, and hold_code then equals the final search code.
- R8: While done is 1, osc_sel_hold is 1 and en_amp, en_fvc_ref, en_fvc_osc, en_count and en_sar are all 0.
- R9: Throughout retention, hold_code and done keep their values whatever cmp_bit does, and trial_code is 0.
- R10: A cal_req seen in retention clears done and osc_sel_hold and raises all enables in the next cycle. hold_code keeps its old value until the next latch.
- R11: A cal_req during calibration or conversion is ignored: the timing and the resulting code are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_req | input | 1 | Request a new calibration (acted on in retention only) |
| cmp_bit | input | 1 | Comparator: 1 when the loop voltage is at or above the trial DAC level |
| trial_code | output | CODE_W | Code driven to the search DAC |
| hold_code | output | CODE_W | Latched code driving the hold DAC |
| osc_sel_hold | output | 1 | 1 selects the hold DAC as oscillator source, 0 the amplifier |
| en_amp | output | 1 | Amplifier enable |
| en_fvc_ref | output | 1 | Reference-side frequency-to-voltage converter enable |
| en_fvc_osc | output | 1 | Oscillator-side frequency-to-voltage converter enable |
| en_count | output | 1 | Counter enable |
| en_sar | output | 1 | Converter logic enable |
| done | output | 1 | Calibration complete, code held |

## Verification
The assertions assume that cmp_bit is a settled function of the trial code presented during the same cycle, the way a comparator in front of a stable input behaves. They also assume that cal_req is synchronous to the reference clock. The bench models the comparator as a combinational compare of trial_code against a fixed target, so the search must return that target exactly. It drives cal_req only on the falling edge. Random comparator toggling is applied only in retention, where the controller must ignore it.

// File: rtl/clk_cal_pkg.sv
package clk_cal_pkg;
    typedef enum logic [1:0] {
        PH_CAL   = 2'd0,
        PH_CONV  = 2'd1,
        PH_LATCH = 2'd2,
        PH_RET   = 2'd3
    } cal_phase_e;

    // enable vector bit order: amp, fvc_ref, fvc_osc, count, sar
    localparam int unsigned N_EN    = 5;
    localparam int unsigned EN_AMP  = 0;
    localparam int unsigned EN_FVR  = 1;
    localparam int unsigned EN_FVO  = 2;
    localparam int unsigned EN_CNT  = 3;
    localparam int unsigned EN_SAR  = 4;
endpackage

// File: rtl/cal_settle_timer.sv
module cal_settle_timer #(
    parameter int unsigned SETTLE_CYCLES = 64,
    parameter int unsigned CNT_W         = $clog2(SETTLE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (run) s_d.cnt = s_q.cnt + CNT_W'(1);
        else     s_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign expired = run && (s_q.cnt == LAST);

    // R3: the count never passes the settle limit while running
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (s_q.cnt <= LAST));
endmodule

// File: rtl/cal_sar_engine.sv
module cal_sar_engine #(
    parameter int unsigned CODE_W = 10,
    parameter int unsigned IDX_W  = $clog2(CODE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic              clear,
    input  logic              cmp_bit,
    output logic [CODE_W-1:0] trial_code,
    output logic              last_step
);
    localparam logic [CODE_W-1:0] MID   = CODE_W'(1) << (CODE_W - 1);
    localparam logic [IDX_W-1:0]  TOP_I = IDX_W'(CODE_W - 1);

    typedef struct packed {
        logic [CODE_W-1:0] trial;
        logic [IDX_W-1:0]  idx;
    } sar_t;

    sar_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.trial = MID;
            s_d.idx   = TOP_I;
        end else if (step) begin
            s_d.trial[s_q.idx] = cmp_bit;
            if (s_q.idx != '0) begin
                s_d.trial[s_q.idx - IDX_W'(1)] = 1'b1;
                s_d.idx = s_q.idx - IDX_W'(1);
            end
        end else if (clear) begin
            s_d.trial = '0;
            s_d.idx   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign trial_code = s_q.trial;
    assign last_step  = step && (s_q.idx == '0);

    // R4: the search opens at mid-scale
    p_mid_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (trial_code == MID));
    // R6: a high comparator clears no bit
    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cmp_bit) |=> ((trial_code & $past(trial_code)) == $past(trial_code)));
    // R6: a low comparator never adds a set bit
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cmp_bit) |=> ($countones(trial_code) <= $countones($past(trial_code))));
endmodule

// File: rtl/cal_hold_bank.sv
module cal_hold_bank
    import clk_cal_pkg::*;
#(
    parameter int unsigned CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch,
    input  logic              rearm,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] hold_code,
    output logic              done,
    output logic              osc_sel_hold,
    output logic [N_EN-1:0]   en_vec
);
    typedef struct packed {
        logic [CODE_W-1:0] hold;
        logic              done;
        logic              sel;
        logic [N_EN-1:0]   en;
    } hb_t;

    hb_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (latch) begin
            s_d.hold = code_in;
            s_d.done = 1'b1;
            s_d.sel  = 1'b1;
            s_d.en   = '0;
        end else if (rearm) begin
            s_d.done = 1'b0;
            s_d.sel  = 1'b0;
            s_d.en   = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.hold <= '0;
            s_q.done <= 1'b0;
            s_q.sel  <= 1'b0;
            s_q.en   <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign hold_code    = s_q.hold;
    assign done         = s_q.done;
    assign osc_sel_hold = s_q.sel;
    assign en_vec       = s_q.en;

    // R8: retention means hold source and every loop block off
    p_off_when_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (osc_sel_hold && (en_vec == '0)));
    // R9: held code does not move while retained
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rearm) |=> (done && $stable(hold_code)));
    // R10: a restart powers the loop back up
    p_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (!done && !osc_sel_hold && (en_vec == '1)));
endmodule

// File: rtl/clk_cal_hold_ctrl.sv
module clk_cal_hold_ctrl
    import clk_cal_pkg::*;
#(
    parameter int unsigned CODE_W        = 10,
    parameter int unsigned SETTLE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_req,
    input  logic              cmp_bit,
    output logic [CODE_W-1:0] trial_code,
    output logic [CODE_W-1:0] hold_code,
    output logic              osc_sel_hold,
    output logic              en_amp,
    output logic              en_fvc_ref,
    output logic              en_fvc_osc,
    output logic              en_count,
    output logic              en_sar,
    output logic              done
);
    typedef struct packed {
        cal_phase_e phase;
    } fsm_t;

    fsm_t s_d, s_q;
    logic settle_done, sar_last;
    logic [N_EN-1:0] en_vec;

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_CAL:   if (settle_done) s_d.phase = PH_CONV;
            PH_CONV:  if (sar_last)    s_d.phase = PH_LATCH;
            PH_LATCH:                  s_d.phase = PH_RET;
            PH_RET:   if (cal_req)     s_d.phase = PH_CAL;
            default:                   s_d.phase = PH_CAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.phase <= PH_CAL;
        else        s_q <= s_d;
    end

    cal_settle_timer #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.phase == PH_CAL),
        .expired (settle_done)
    );

    cal_sar_engine #(
        .CODE_W (CODE_W)
    ) u_sar (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      ((s_q.phase == PH_CAL) && settle_done),
        .step       (s_q.phase == PH_CONV),
        .clear      (s_q.phase == PH_LATCH),
        .cmp_bit    (cmp_bit),
        .trial_code (trial_code),
        .last_step  (sar_last)
    );

    cal_hold_bank #(
        .CODE_W (CODE_W)
    ) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .latch        (s_q.phase == PH_LATCH),
        .rearm        ((s_q.phase == PH_RET) && cal_req),
        .code_in      (trial_code),
        .hold_code    (hold_code),
        .done         (done),
        .osc_sel_hold (osc_sel_hold),
        .en_vec       (en_vec)
    );

    assign en_amp     = en_vec[EN_AMP];
    assign en_fvc_ref = en_vec[EN_FVR];
    assign en_fvc_osc = en_vec[EN_FVO];
    assign en_count   = en_vec[EN_CNT];
    assign en_sar     = en_vec[EN_SAR];

    // R1: conversion is entered only from calibration
    p_order_conv_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_CONV) |-> ($past(s_q.phase) == PH_CAL || $past(s_q.phase) == PH_CONV));
    // R7: latch follows the last decision
    p_latch_after_conv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_LATCH) |-> ($past(s_q.phase) == PH_CONV));
    // R7: done only rises out of the latch cycle
    p_done_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(s_q.phase) == PH_LATCH));
    // R11: a request mid-conversion does not restart calibration
    p_ignore_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.phase == PH_CONV) && cal_req) |=> (s_q.phase != PH_CAL));
    // R9: the search DAC is idle during retention
    p_idle_trial_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_RET) |-> (trial_code == '0));
endmodule

// File: tb/sim_clk_cal_hold_ctrl.sv
module sim_clk_cal_hold_ctrl;
    localparam int unsigned CW = 10;
    localparam int unsigned SC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_req = 1'b0;
    logic noise_on = 1'b0;
    logic noise_bit = 1'b0;
    logic [CW-1:0] target = '0;
    logic cmp_bit;
    logic [CW-1:0] trial_code, hold_code;
    logic osc_sel_hold, en_amp, en_fvc_ref, en_fvc_osc, en_count, en_sar, done;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    assign cmp_bit = noise_on ? noise_bit : (target >= trial_code);

    clk_cal_hold_ctrl #(.CODE_W(CW), .SETTLE_CYCLES(SC)) u0 (
        .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .cmp_bit(cmp_bit),
        .trial_code(trial_code), .hold_code(hold_code), .osc_sel_hold(osc_sel_hold),
        .en_amp(en_amp), .en_fvc_ref(en_fvc_ref), .en_fvc_osc(en_fvc_osc),
        .en_count(en_count), .en_sar(en_sar), .done(done)
    );

    function automatic logic [4:0] ens();
        return {en_sar, en_count, en_fvc_osc, en_fvc_ref, en_amp};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // runs one calibration from the first calibrate cycle; poke=1 pulses cal_req mid-way
    task automatic run_cal(input logic [CW-1:0] tgt, input bit poke);
        logic [CW-1:0] exp_t;
        target = tgt;
        for (int i = 1; i <= int'(SC); i++) begin
            if (poke && i == 3) cal_req = 1'b1;
            tick();
            cal_req = 1'b0;
            if (i < int'(SC)) chk(trial_code == 0, "R3 trial idle in calibrate", trial_code, 0);
            if (i < int'(SC)) chk(done == 0 && ens() == 5'h1f, "R3 loop on in calibrate", ens(), 5'h1f);
        end
        chk(trial_code == 10'h200, "R4 first trial", trial_code, 10'h200);
        exp_t = 10'h200;
        for (int k = CW - 1; k >= 0; k--) begin
            chk(trial_code == exp_t, "R5 trial step", trial_code, exp_t);
            if (!(tgt >= exp_t)) exp_t[k] = 1'b0;  // R6 clear on low compare
            if (k > 0) exp_t[k-1] = 1'b1;
            if (poke && k == 5) cal_req = 1'b1;
            tick();
            cal_req = 1'b0;
        end
        chk(done == 0, "R7 not done in latch cycle", done, 0);
        chk(trial_code == exp_t, "R6 final search code", trial_code, exp_t);
        tick();
        chk(done == 1, "R7 done after settle+11", done, 1);
        chk(hold_code == tgt, "R7 held code", hold_code, tgt);
        chk(osc_sel_hold == 1, "R8 source select", osc_sel_hold, 1);
        chk(ens() == 0, "R8 loop off", ens(), 0);
        chk(trial_code == 0, "R9 trial idle", trial_code, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cal_req = 1'b0;
        noise_on = 1'b0;
        repeat (3) @(negedge clk);
        chk(done == 0 && osc_sel_hold == 0, "R2 flags", {done, osc_sel_hold}, 0);
        chk(hold_code == 0 && trial_code == 0, "R2 codes", hold_code, 0);
        chk(ens() == 5'h1f, "R2 enables", ens(), 5'h1f);
        rst_n = 1'b1;
    endtask

    task automatic t_retain(input logic [CW-1:0] held);
        noise_on = 1'b1;
        for (int i = 0; i < 40; i++) begin
            noise_bit = i[0] ^ i[2];
            tick();
            chk(done == 1 && hold_code == held, "R9 retention stable", hold_code, held);
            chk(trial_code == 0 && ens() == 0, "R9 idle in retention", trial_code, 0);
        end
        noise_on = 1'b0;
    endtask

    task automatic t_recal(input logic [CW-1:0] old_code, input logic [CW-1:0] tgt);
        cal_req = 1'b1;
        tick();
        cal_req = 1'b0;
        chk(done == 0 && osc_sel_hold == 0, "R10 done cleared", done, 0);
        chk(ens() == 5'h1f, "R10 loop re-enabled", ens(), 5'h1f);
        chk(hold_code == old_code, "R10 old code kept", hold_code, old_code);
        chk(trial_code == 0, "R1 restart in calibrate", trial_code, 0);
        run_cal(tgt, 1'b0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        run_cal(10'h187, 1'b0);
        t_retain(10'h187);
        t_recal(10'h187, 10'h000);
        t_recal(10'h000, 10'h3ff);
        t_recal(10'h3ff, 10'h200);
        t_recal(10'h200, 10'h2d9);
        // R11: requests during calibrate and convert change nothing
        t_reset();
        run_cal(10'h155, 1'b1);
        t_retain(10'h155);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule